// File: doc/BRIEF.md
# Serial Port Control Register Bank with Atomic Bit Views

This block is the software-facing register file of a serial port. It has 32-bit registers on a simple valid/write/address/data bus. The control word and the error-interrupt enable word each occupy four consecutive word addresses:

- a plain view that loads the whole word;
- a view that clears every bit written as one;
- a view that sets every bit written as one;
- a view that toggles every bit written as one.

Because of the three alias views, firmware can change single bits in one bus write, with no read-modify-write sequence.

The status word has the same four-address layout. It combines three sticky error flags with live fields that the serial engine drives: a receive-FIFO-empty indication and the fill levels of both FIFOs. The flags are set by hardware event strobes. Software can only clear them, and only through the clear view. The flags, gated by their enables, form a single fault interrupt.

A data window passes words between the bus and the engine. A write to the window emits a one-cycle push strobe together with the word. A read from the window emits a one-cycle pop strobe and returns the engine's receive word. A baud divisor register stores only its low bits. The serial engine is outside this block. Its status inputs and event strobes stand in for it.

Top module: `spi_regbank`

## Requirements
- R1: A write to a plain view (control 0x00, enable word 0x40) loads the full 32-bit word. A read of any of a group's four views returns the current value on `bus_rdata` one cycle after the request. `bus_rdata` then holds that value until the next read.
- R2: A write to the clear view (control 0x04, enable word 0x44) makes the register equal to its old value AND NOT the write data.
- R3: A write to the set view (control 0x08, enable word 0x48) makes the register equal to its old value OR the write data.
- R4: A write to the invert view (control 0x0C, enable word 0x4C) makes the register equal to its old value XOR the write data.
- R5: The baud divisor at 0x30 stores only write bits 8:0. Reads return those bits with bits 31:9 as zero, and `baud_div` shows the stored value.
- R6: The three error flags are sticky:
  - status bit 6 is set by `ev_rx_overrun`;
  - status bit 8 is set by `ev_tx_underrun`;
  - status bit 12 is set by `ev_frame_err`.
  
  A flag stays set until a one is written to its bit at the status clear view 0x14. Writes to the plain, set and invert status views (0x10, 0x18, 0x1C) leave the flags unchanged.
- R7: If a flag's event strobe and a clear of that flag arrive in the same cycle, the flag is set afterwards.
- R8: Status bit 5 mirrors `rx_empty`, bits 20:16 mirror `tx_level` and bits 28:24 mirror `rx_level`. These fields cannot be written, and every other status bit reads as zero.
- R9: `fault_irq` is high exactly when at least one of these pairs is true:
  - flag bit 8 is set and enable-word bit 10 is set;
  - flag bit 6 is set and enable-word bit 11 is set;
  - flag bit 12 is set and enable-word bit 12 is set.
- R10: A write to 0x20 pulses `tx_push` for one cycle in the next cycle, with `tx_word` equal to the written data. A read of 0x20 pulses `rx_pop` in the next cycle and returns the `rx_data` value from the request cycle.
- R11: Words 0x24–0x2C, 0x34–0x3C and 0x50 upward are reserved. Writes to them change no register and no output, and reads of them return zero.
- R12: After reset, all registers, flags, strobes and `bus_rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Bus request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address, bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| ev_rx_overrun | input | 1 | Receive overrun event strobe |
| ev_tx_underrun | input | 1 | Transmit underrun event strobe |
| ev_frame_err | input | 1 | Repeated frame sync event strobe |
| rx_empty | input | 1 | Receive FIFO is empty |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_data | input | 32 | Word at the head of the receive FIFO |
| ctrl_word | output | 32 | Current control word |
| ctrl2_word | output | 32 | Current error-interrupt enable word |
| baud_div | output | BAUD_W | Current baud divisor |
| fault_irq | output | 1 | Enabled error interrupt |
| tx_push | output | 1 | One-cycle strobe: a word for the transmit FIFO |
| tx_word | output | 32 | Word to push |
| rx_pop | output | 1 | One-cycle strobe: the receive word was consumed |

## Verification
A wrong alias or decode state appears at `ctrl_word`, `ctrl2_word` or `baud_div` in the cycle after the offending write. It also appears in the read-back one cycle after any later read. A sticky flag that is lost or not set shows in two ways: `fault_irq` is wrong in the cycle after the event whenever the matching enable is set, and the status read-back is wrong. The bench therefore sweeps all 64 word addresses and every combination of the three flags with the three enables. It checks each result one cycle after the stimulus.

// File: rtl/spi_regbank_pkg.sv
package spi_regbank_pkg;

    localparam int WORD_W = 32;

    // view is selected by address bits 3:2 inside a four-word group
    typedef enum logic [1:0] {
        VIEW_PLAIN = 2'd0,
        VIEW_CLR   = 2'd1,
        VIEW_SET   = 2'd2,
        VIEW_INV   = 2'd3
    } view_e;

    // group is selected by address bits 6:4
    typedef enum logic [2:0] {
        GRP_CTRL  = 3'd0,
        GRP_STAT  = 3'd1,
        GRP_BUF   = 3'd2,
        GRP_BAUD  = 3'd3,
        GRP_CTRL2 = 3'd4,
        GRP_RSV5  = 3'd5,
        GRP_RSV6  = 3'd6,
        GRP_RSV7  = 3'd7
    } grp_e;

    // status word bit positions
    localparam int ST_RXEMPTY = 5;
    localparam int ST_OVR     = 6;
    localparam int ST_UDR     = 8;
    localparam int ST_FRM     = 12;
    localparam int ST_TXLVL   = 16;
    localparam int ST_RXLVL   = 24;

    // enable word bit positions
    localparam int EN_UDR = 10;
    localparam int EN_OVR = 11;
    localparam int EN_FRM = 12;

    // index of each sticky flag in the internal flag vector
    localparam int FLG_OVR = 0;
    localparam int FLG_UDR = 1;
    localparam int FLG_FRM = 2;
    localparam int NFLAGS  = 3;

    // number of writable four-view configuration groups
    localparam int NCFG = 2;

endpackage

// File: rtl/spi_regbank_decode.sv
module spi_regbank_decode
    import spi_regbank_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output grp_e              grp,
    output view_e             view,
    output logic              hit
);
    localparam int GRP_LSB = 4;
    localparam int GRP_MSB = 6;

    logic upper_set;
    logic unused_low;

    assign unused_low = ^addr[1:0];

    generate
        if (ADDR_W > GRP_MSB + 1) begin : g_upper
            assign upper_set = |addr[ADDR_W-1:GRP_MSB+1];
        end else begin : g_noupper
            assign upper_set = 1'b0;
        end
    endgenerate

    always_comb begin
        grp  = grp_e'(addr[GRP_MSB:GRP_LSB]);
        view = view_e'(addr[3:2]);
        hit  = 1'b0;
        if (!upper_set) begin
            unique case (grp)
                GRP_CTRL, GRP_STAT, GRP_CTRL2: hit = 1'b1;
                GRP_BUF, GRP_BAUD:             hit = (view == VIEW_PLAIN);
                default:                       hit = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/spi_regbank_alias.sv
module spi_regbank_alias
    import spi_regbank_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] wdata,
    input  view_e        view,
    input  logic         we,
    output logic [W-1:0] nxt
);
    always_comb begin
        nxt = cur;
        if (we) begin
            unique case (view)
                VIEW_PLAIN: nxt = wdata;
                VIEW_CLR:   nxt = cur & ~wdata;
                VIEW_SET:   nxt = cur | wdata;
                VIEW_INV:   nxt = cur ^ wdata;
                default:    nxt = cur;
            endcase
        end
    end

endmodule

// File: rtl/spi_regbank_sticky.sv
module spi_regbank_sticky #(
    parameter int N = 3
) (
    input  logic [N-1:0] cur,
    input  logic [N-1:0] set_ev,
    input  logic [N-1:0] clr_req,
    output logic [N-1:0] nxt
);
    // the event term is ORed in last, so hardware beats a software clear
    always_comb begin
        for (int i = 0; i < N; i++) begin
            nxt[i] = (cur[i] & ~clr_req[i]) | set_ev[i];
        end
    end

endmodule

// File: rtl/spi_regbank.sv
module spi_regbank
    import spi_regbank_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BAUD_W = 9,
    parameter int LVL_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              ev_rx_overrun,
    input  logic              ev_tx_underrun,
    input  logic              ev_frame_err,
    input  logic              rx_empty,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic [31:0]       rx_data,
    output logic [31:0]       ctrl_word,
    output logic [31:0]       ctrl2_word,
    output logic [BAUD_W-1:0] baud_div,
    output logic              fault_irq,
    output logic              tx_push,
    output logic [31:0]       tx_word,
    output logic              rx_pop
);
    localparam int CFG_CTRL  = 0;
    localparam int CFG_CTRL2 = 1;

    typedef struct packed {
        logic [NCFG-1:0][WORD_W-1:0] cfg;
        logic [BAUD_W-1:0]           baud;
        logic [NFLAGS-1:0]           flags;
        logic [WORD_W-1:0]           rdata;
        logic                        push;
        logic [WORD_W-1:0]           txw;
        logic                        pop;
    } state_t;

    state_t st_d, st_q;

    grp_e  dec_grp;
    view_e dec_view;
    logic  dec_hit;
    logic  wr, rd;

    logic [NCFG-1:0][WORD_W-1:0] cfg_nxt;
    logic [NFLAGS-1:0]           flag_nxt;
    logic [NFLAGS-1:0]           flag_ev;
    logic [NFLAGS-1:0]           flag_clr;
    logic [NFLAGS-1:0]           flag_en;
    logic [WORD_W-1:0]           stat_word;
    logic [NFLAGS-1:0]           flags_q;

    assign wr = bus_valid &&  bus_write;
    assign rd = bus_valid && !bus_write;

    spi_regbank_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .grp  (dec_grp),
        .view (dec_view),
        .hit  (dec_hit)
    );

    // one alias engine per writable four-view group
    generate
        for (genvar g = 0; g < NCFG; g++) begin : g_cfg
            localparam grp_e MY_GRP = (g == CFG_CTRL) ? GRP_CTRL : GRP_CTRL2;
            spi_regbank_alias #(.W(WORD_W)) u_alias (
                .cur   (st_q.cfg[g]),
                .wdata (bus_wdata),
                .view  (dec_view),
                .we    (wr && dec_hit && (dec_grp == MY_GRP)),
                .nxt   (cfg_nxt[g])
            );
        end
    endgenerate

    always_comb begin
        flag_ev           = '0;
        flag_ev[FLG_OVR]  = ev_rx_overrun;
        flag_ev[FLG_UDR]  = ev_tx_underrun;
        flag_ev[FLG_FRM]  = ev_frame_err;
        flag_clr          = '0;
        if (wr && dec_hit && dec_grp == GRP_STAT && dec_view == VIEW_CLR) begin
            flag_clr[FLG_OVR] = bus_wdata[ST_OVR];
            flag_clr[FLG_UDR] = bus_wdata[ST_UDR];
            flag_clr[FLG_FRM] = bus_wdata[ST_FRM];
        end
    end

    spi_regbank_sticky #(.N(NFLAGS)) u_sticky (
        .cur     (st_q.flags),
        .set_ev  (flag_ev),
        .clr_req (flag_clr),
        .nxt     (flag_nxt)
    );

    always_comb begin
        stat_word                         = '0;
        stat_word[ST_RXEMPTY]             = rx_empty;
        stat_word[ST_OVR]                 = st_q.flags[FLG_OVR];
        stat_word[ST_UDR]                 = st_q.flags[FLG_UDR];
        stat_word[ST_FRM]                 = st_q.flags[FLG_FRM];
        stat_word[ST_TXLVL +: LVL_W]      = tx_level;
        stat_word[ST_RXLVL +: LVL_W]      = rx_level;
    end

    always_comb begin
        st_d       = st_q;
        st_d.cfg   = cfg_nxt;
        st_d.flags = flag_nxt;
        st_d.push  = wr && dec_hit && (dec_grp == GRP_BUF);
        st_d.pop   = rd && dec_hit && (dec_grp == GRP_BUF);
        if (wr && dec_hit && dec_grp == GRP_BUF) begin
            st_d.txw = bus_wdata;
        end
        if (wr && dec_hit && dec_grp == GRP_BAUD) begin
            st_d.baud = bus_wdata[BAUD_W-1:0];
        end
        if (rd) begin
            st_d.rdata = '0;
            if (dec_hit) begin
                unique case (dec_grp)
                    GRP_CTRL:  st_d.rdata = st_q.cfg[CFG_CTRL];
                    GRP_STAT:  st_d.rdata = stat_word;
                    GRP_BUF:   st_d.rdata = rx_data;
                    GRP_BAUD:  st_d.rdata = WORD_W'(st_q.baud);
                    GRP_CTRL2: st_d.rdata = st_q.cfg[CFG_CTRL2];
                    default:   st_d.rdata = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        flag_en          = '0;
        flag_en[FLG_OVR] = st_q.cfg[CFG_CTRL2][EN_OVR];
        flag_en[FLG_UDR] = st_q.cfg[CFG_CTRL2][EN_UDR];
        flag_en[FLG_FRM] = st_q.cfg[CFG_CTRL2][EN_FRM];
    end

    assign flags_q    = st_q.flags;
    assign fault_irq  = |(st_q.flags & flag_en);
    assign bus_rdata  = st_q.rdata;
    assign ctrl_word  = st_q.cfg[CFG_CTRL];
    assign ctrl2_word = st_q.cfg[CFG_CTRL2];
    assign baud_div   = st_q.baud;
    assign tx_push    = st_q.push;
    assign tx_word    = st_q.txw;
    assign rx_pop     = st_q.pop;

endmodule

// File: rtl/spi_regbank_chk.sv
module spi_regbank_chk #(
    parameter int ADDR_W = 8,
    parameter int BAUD_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              ev_rx_overrun,
    input logic [31:0]       ctrl_word,
    input logic [31:0]       ctrl2_word,
    input logic              fault_irq,
    input logic              tx_push,
    input logic [31:0]       tx_word,
    input logic              rx_pop,
    input logic [2:0]        flags_q
);
    logic wr_now, rd_now;
    assign wr_now = bus_valid &&  bus_write;
    assign rd_now = bus_valid && !bus_write;

    AST_CTRL_CLR_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_now && bus_addr == ADDR_W'(8'h04)) |=> (ctrl_word == ($past(ctrl_word) & ~$past(bus_wdata)))); // R2

    AST_CTRL_SET_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_now && bus_addr == ADDR_W'(8'h48)) |=> (ctrl2_word == ($past(ctrl2_word) | $past(bus_wdata)))); // R3

    AST_CTRL_INV_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_now && bus_addr == ADDR_W'(8'h0C)) |=> (ctrl_word == ($past(ctrl_word) ^ $past(bus_wdata)))); // R4

    AST_BAUD_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_now && bus_addr == ADDR_W'(8'h30)) |=> (bus_rdata[31:BAUD_W] == '0)); // R5

    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q[0] && !(wr_now && bus_addr == ADDR_W'(8'h14) && bus_wdata[6])) |=> flags_q[0]); // R6

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx_overrun |=> flags_q[0]); // R7

    AST_FAULT_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rx_overrun && ctrl2_word[11] && !wr_now) |=> fault_irq); // R9

    AST_PUSH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_now && bus_addr == ADDR_W'(8'h20)) |=> (tx_push && tx_word == $past(bus_wdata))); // R10

    AST_POP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> $past(rd_now)); // R10

endmodule

bind spi_regbank spi_regbank_chk #(.ADDR_W(ADDR_W), .BAUD_W(BAUD_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_valid     (bus_valid),
    .bus_write     (bus_write),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .ev_rx_overrun (ev_rx_overrun),
    .ctrl_word     (ctrl_word),
    .ctrl2_word    (ctrl2_word),
    .fault_irq     (fault_irq),
    .tx_push       (tx_push),
    .tx_word       (tx_word),
    .rx_pop        (rx_pop),
    .flags_q       (flags_q)
);

// File: tb/sim_spi_regbank.sv
module sim_spi_regbank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ev_ovr = 1'b0, ev_udr = 1'b0, ev_frm = 1'b0;
    logic        rx_empty = 1'b0;
    logic [4:0]  tx_level = '0, rx_level = '0;
    logic [31:0] rx_data = '0;
    logic [31:0] ctrl_word, ctrl2_word, tx_word;
    logic [8:0]  baud_div;
    logic        fault_irq, tx_push, rx_pop;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_cfg [2];
    logic [8:0]  m_baud;
    logic [2:0]  m_flags;   // [0] overrun bit 6, [1] underrun bit 8, [2] frame bit 12

    always #5 clk = ~clk;

    spi_regbank u0 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_rx_overrun(ev_ovr), .ev_tx_underrun(ev_udr), .ev_frame_err(ev_frm),
        .rx_empty(rx_empty), .tx_level(tx_level), .rx_level(rx_level), .rx_data(rx_data),
        .ctrl_word(ctrl_word), .ctrl2_word(ctrl2_word), .baud_div(baud_div),
        .fault_irq(fault_irq), .tx_push(tx_push), .tx_word(tx_word), .rx_pop(rx_pop)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse(input logic [2:0] f);
        ev_ovr = f[0]; ev_udr = f[1]; ev_frm = f[2];
        @(negedge clk);
        ev_ovr = 1'b0; ev_udr = 1'b0; ev_frm = 1'b0;
    endtask

    function automatic logic [31:0] stat_exp();
        return (32'(rx_level) << 24) | (32'(tx_level) << 16) | (32'(m_flags[2]) << 12)
             | (32'(m_flags[1]) << 8) | (32'(m_flags[0]) << 6) | (32'(rx_empty) << 5);
    endfunction

    function automatic bit is_rsv(input int w);
        return !((w <= 7) || (w == 8) || (w == 12) || (w >= 16 && w <= 19));
    endfunction

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R12 act=%h exp=%h", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        logic [31:0] v;
        logic [31:0] p, m;
        m_cfg[0] = '0; m_cfg[1] = '0; m_baud = '0; m_flags = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        chk("R12 ctrl", ctrl_word, 0);
        chk("R12 ctrl2", ctrl2_word, 0);
        chk("R12 baud", 32'(baud_div), 0);
        chk("R12 fault", 32'(fault_irq), 0);
        chk("R12 rdata", bus_rdata, 0);
        chk("R12 push", 32'(tx_push), 0);
        rd(8'h10, v);
        chk("R12 status", v, 0);

        // R1-R4: alias views on both configuration groups
        for (int g = 0; g < 2; g++) begin
            logic [7:0] base;
            base = (g == 0) ? 8'h00 : 8'h40;
            for (int i = 0; i < 6; i++) begin
                p = 32'h9E37_79B9 * (i + 1) + 32'h1357 * g;
                m = 32'hA5C3_0F71 ^ (p >> (i + 3));
                wr(base, p); m_cfg[g] = p;
                for (int vw = 0; vw < 4; vw++) begin
                    rd(base + 8'(vw * 4), v);
                    chk("R1 view readback", v, m_cfg[g]);
                end
                wr(base + 8'h04, m); m_cfg[g] = m_cfg[g] & ~m;
                rd(base, v); chk("R2 clear view", v, m_cfg[g]);
                wr(base + 8'h08, m >> 4); m_cfg[g] = m_cfg[g] | (m >> 4);
                rd(base + 8'h08, v); chk("R3 set view", v, m_cfg[g]);
                wr(base + 8'h0C, ~m); m_cfg[g] = m_cfg[g] ^ ~m;
                rd(base + 8'h0C, v); chk("R4 invert view", v, m_cfg[g]);
                chk("R1 ctrl out", g == 0 ? ctrl_word : ctrl2_word, m_cfg[g]);
            end
        end

        // R5 baud width
        wr(8'h30, 32'hFFFF_FFFF); m_baud = 9'h1FF;
        rd(8'h30, v); chk("R5 baud all ones", v, 32'h1FF);
        chk("R5 baud out", 32'(baud_div), 32'h1FF);
        wr(8'h30, 32'h0000_1234); m_baud = 9'h034;
        rd(8'h30, v); chk("R5 baud trunc", v, 32'h034);

        // R8 read-only status fields across levels
        for (int l = 0; l <= 16; l++) begin
            tx_level = 5'(l); rx_level = 5'(31 - l); rx_empty = l[0];
            wr(8'h10, 32'hFFFF_FFFF);
            wr(8'h18, 32'hFFFF_FFFF);
            rd(8'h10 + 8'((l % 4) * 4), v);
            chk("R8 status fields", v, stat_exp());
        end

        // R6 sticky flags
        pulse(3'b001); m_flags = 3'b001;
        rd(8'h10, v); chk("R6 overrun set", v, stat_exp());
        wr(8'h10, 32'h0); wr(8'h18, 32'h40); wr(8'h1C, 32'h40);
        rd(8'h10, v); chk("R6 non-clear views ignored", v, stat_exp());
        wr(8'h14, 32'h100);
        rd(8'h14, v); chk("R6 other bit clear keeps", v, stat_exp());
        wr(8'h14, 32'h40); m_flags = 3'b000;
        rd(8'h10, v); chk("R6 clear view clears", v, stat_exp());
        pulse(3'b110); m_flags = 3'b110;
        rd(8'h10, v); chk("R6 underrun+frame", v, stat_exp());

        // R7 event beats clear in the same cycle
        ev_udr = 1'b1;
        wr(8'h14, 32'h1140);
        ev_udr = 1'b0; m_flags = 3'b010;
        rd(8'h10, v); chk("R7 event wins", v, stat_exp());
        wr(8'h14, 32'h1140); m_flags = 3'b000;

        // R9 fault output over all flag/enable combinations
        for (int f = 0; f < 8; f++) begin
            for (int e = 0; e < 8; e++) begin
                logic [31:0] en;
                en = (32'(e & 1) << 11) | (32'((e >> 1) & 1) << 10) | (32'((e >> 2) & 1) << 12);
                wr(8'h14, 32'h1140);
                wr(8'h40, en); m_cfg[1] = en;
                pulse(3'(f)); m_flags = 3'(f);
                chk("R9 fault", 32'(fault_irq), 32'((f & e) != 0));
            end
        end
        wr(8'h14, 32'h1140); m_flags = 3'b000;

        // R10 data window
        for (int i = 0; i < 4; i++) begin
            p = 32'hC001_0000 + 32'(i * 77);
            bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 8'h20; bus_wdata = p;
            @(negedge clk);
            bus_valid = 1'b0; bus_write = 1'b0;
            chk("R10 push strobe", 32'(tx_push), 1);
            chk("R10 push word", tx_word, p);
            @(negedge clk);
            chk("R10 push one cycle", 32'(tx_push), 0);
            rx_data = ~p;
            rd(8'h20, v);
            chk("R10 pop data", v, ~p);
            chk("R10 pop strobe", 32'(rx_pop), 1);
            @(negedge clk);
            chk("R10 pop one cycle", 32'(rx_pop), 0);
        end

        // R11 reserved sweep over all 64 words
        for (int w = 0; w < 64; w++) begin
            if (is_rsv(w)) begin
                wr(8'(w * 4), 32'hFFFF_FFFF);
                chk("R11 no push", 32'(tx_push), 0);
                rd(8'(w * 4), v);
                chk("R11 reads zero", v, 0);
            end
        end
        chk("R11 ctrl kept", ctrl_word, m_cfg[0]);
        chk("R11 ctrl2 kept", ctrl2_word, m_cfg[1]);
        chk("R11 baud kept", 32'(baud_div), 32'(m_baud));
        rd(8'h10, v); chk("R11 status kept", v, stat_exp());

        finish_run();
    end

endmodule